// File: doc/BRIEF.md
# Atomic Bank Reservation Controller

This block holds one reservation of a memory bank so that a master can complete an atomic two-step sequence without another master getting in between. It watches every access the arbiter grants. For each one it receives the master number, the bank number, the direction, and that bank's two-bit atomic mode. A bank in read-after-write mode is reserved by a write and freed by a read from the same master to the same bank. A bank in write-after-read mode works the other way round: a read reserves it and a write frees it.

While a reservation is held, the block raises a block line for every master except the owner. The arbiter combines these lines with the reported bank so that no other master is granted that bank. A watchdog drops the reservation if the owner does not free it within a fixed number of clock cycles. When error reporting is enabled, a timeout produces a one-cycle error pulse and sets a sticky flag that software clears.

Top module: `atomic_resv_ctrl`

## Requirements
- R1: With no reservation held, a granted write (`acc_write`=1) to a bank whose mode is 2'b01 creates a reservation. From the next cycle `resv_active`=1, and `resv_owner` and `resv_bank` report the accessing master and bank.
- R2: With no reservation held, a granted read (`acc_write`=0) to a bank whose mode is 2'b10 creates a reservation in the same way.
- R3: Modes 2'b00 and 2'b11, and mode 2'b01 or 2'b10 with the other direction, never create a reservation.
- R4: While a reservation is held, bit i of `master_block` is 1 for every master i except the owner, whose bit is 0. With no reservation held, `master_block` is all zero.
- R5: An access by the owner to the reserved bank in the freeing direction releases the reservation on the next cycle. The freeing direction is a read for mode 01 and a write for mode 10. The following accesses leave the reservation unchanged: accesses by other masters, accesses by the owner to other banks, and atomic accesses made while a reservation is held.
- R6: An access by the owner to the reserved bank in the reserving direction keeps the reservation and restarts the timeout window. After such an access the reservation stays held for exactly TIMEOUT more cycles unless it is released.
- R7: A reservation that is neither released nor renewed stays held for exactly TIMEOUT cycles (256 by default) after it is created, and is then dropped.
- R8: When a reservation times out while `err_enable`=1, `err_pulse` is high for exactly the one cycle in which `resv_active` first reads 0, and `err_sticky` becomes 1. When `err_enable`=0, a timeout produces neither.
- R9: `err_sticky` stays 1 until `err_clear` is sampled high, and then reads 0 from the next cycle. If a new error occurs in the same cycle as the clear, the error wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A granted access is presented this cycle |
| acc_master | input | MW | Number of the accessing master |
| acc_bank | input | BW | Number of the bank accessed |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_mode | input | 2 | Atomic mode of the accessed bank |
| err_enable | input | 1 | Enables error reporting on timeout |
| err_clear | input | 1 | Clears the sticky error flag |
| resv_active | output | 1 | A reservation is held |
| resv_owner | output | MW | Master that holds the reservation |
| resv_bank | output | BW | Bank that is reserved |
| master_block | output | NUM_MASTERS | Per-master block lines for the reserved bank |
| err_pulse | output | 1 | One-cycle timeout error |
| err_sticky | output | 1 | Sticky timeout error flag |

## Verification
The assertions check properties that must hold on every cycle. The block vector has exactly one clear bit while a reservation is held and is zero when none is held. The reserved bank cannot change while a reservation stays held. An error pulse lasts one cycle, coincides with the fall of the reservation, is set only when reporting was enabled, and always sets the sticky flag. Only the bench scenarios can show the rest. These are: which mode and direction pairs create a reservation, which accesses release it and which leave it alone, the exact length of the timeout window both from creation and from a renewal, and the effect of disabling error reporting.

// File: rtl/atomic_resv_ctrl.sv
module atomic_resv_ctrl #(
  parameter int NUM_MASTERS = 4,
  parameter int NUM_BANKS   = 8,
  parameter int TIMEOUT     = 256,
  localparam int MW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_valid,
  input  logic [MW-1:0]          acc_master,
  input  logic [BW-1:0]          acc_bank,
  input  logic                   acc_write,
  input  logic [1:0]             acc_mode,
  input  logic                   err_enable,
  input  logic                   err_clear,
  output logic                   resv_active,
  output logic [MW-1:0]          resv_owner,
  output logic [BW-1:0]          resv_bank,
  output logic [NUM_MASTERS-1:0] master_block,
  output logic                   err_pulse,
  output logic                   err_sticky
);

  localparam int TW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT - 1);

  logic          kind_war;
  logic [TW-1:0] tmr;

  wire own_hit     = acc_valid && resv_active && (acc_master == resv_owner) && (acc_bank == resv_bank);
  wire release_hit = own_hit && (acc_write == kind_war);
  wire renew_hit   = own_hit && !release_hit;
  wire start_raw   = acc_valid && !resv_active && (acc_mode == 2'b01) && acc_write;
  wire start_war   = acc_valid && !resv_active && (acc_mode == 2'b10) && !acc_write;
  wire expire      = resv_active && !own_hit && (tmr == TLAST);
  wire err_now     = expire && err_enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_active <= 1'b0;
      resv_owner  <= '0;
      resv_bank   <= '0;
      kind_war    <= 1'b0;
      tmr         <= '0;
      err_pulse   <= 1'b0;
      err_sticky  <= 1'b0;
    end else begin
      err_pulse <= err_now;
      if (err_now)        err_sticky <= 1'b1;
      else if (err_clear) err_sticky <= 1'b0;

      if (start_raw || start_war) begin
        resv_active <= 1'b1;
        resv_owner  <= acc_master;
        resv_bank   <= acc_bank;
        kind_war    <= start_war;
        tmr         <= '0;
      end else if (release_hit || expire) begin
        resv_active <= 1'b0;
        tmr         <= '0;
      end else if (renew_hit) begin
        tmr <= '0;
      end else if (resv_active) begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_block
    assign master_block[i] = resv_active && (resv_owner != MW'(i));
  end

endmodule

// File: rtl/atomic_resv_ctrl_chk.sv
module atomic_resv_ctrl_chk #(
  parameter int NUM_MASTERS = 4,
  parameter int NUM_BANKS   = 8,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   err_enable,
  input logic                   err_clear,
  input logic                   resv_active,
  input logic [BW-1:0]          resv_bank,
  input logic [NUM_MASTERS-1:0] master_block,
  input logic                   err_pulse,
  input logic                   err_sticky
);

  p_idle_unblocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !resv_active |-> master_block == '0);

  p_one_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resv_active |-> $countones(master_block) == NUM_MASTERS - 1);

  p_bank_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (resv_active && $past(resv_active)) |-> $stable(resv_bank));

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  p_pulse_on_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (!resv_active && $past(resv_active)));

  p_pulse_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(err_enable));

  p_sticky_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_sticky);

  p_sticky_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_clear) && !err_pulse) |-> !err_sticky);

endmodule

bind atomic_resv_ctrl atomic_resv_ctrl_chk #(
  .NUM_MASTERS(NUM_MASTERS),
  .NUM_BANKS(NUM_BANKS)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .err_enable(err_enable),
  .err_clear(err_clear),
  .resv_active(resv_active),
  .resv_bank(resv_bank),
  .master_block(master_block),
  .err_pulse(err_pulse),
  .err_sticky(err_sticky)
);

// File: tb/atomic_resv_ctrl_bench.sv
module atomic_resv_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 4;
  localparam int NB = 8;
  localparam int TO = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic [1:0] acc_master = '0;
  logic [2:0] acc_bank = '0;
  logic       acc_write = 1'b0;
  logic [1:0] acc_mode = '0;
  logic       err_enable = 1'b0;
  logic       err_clear = 1'b0;
  logic       resv_active;
  logic [1:0] resv_owner;
  logic [2:0] resv_bank;
  logic [3:0] master_block;
  logic       err_pulse;
  logic       err_sticky;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atomic_resv_ctrl #(.NUM_MASTERS(NM), .NUM_BANKS(NB), .TIMEOUT(TO)) u_atomic_resv_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_master(acc_master),
    .acc_bank(acc_bank), .acc_write(acc_write), .acc_mode(acc_mode),
    .err_enable(err_enable), .err_clear(err_clear), .resv_active(resv_active),
    .resv_owner(resv_owner), .resv_bank(resv_bank), .master_block(master_block),
    .err_pulse(err_pulse), .err_sticky(err_sticky));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic acc(input int m, input int b, input bit w, input int mode);
    acc_master = 2'(m); acc_bank = 3'(b); acc_write = w; acc_mode = 2'(mode);
    acc_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic hold_len(output int n, output int pulses);
    n = 0; pulses = 0;
    while (resv_active && n < 1000) begin
      n++;
      @(negedge clk);
      pulses += int'(err_pulse);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic int blk(input int owner);
    return 15 & ~(1 << owner);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    int n, p;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R4 reset active", resv_active, 0);
    check("R4 reset block", master_block, 0);
    check("R8 reset pulse", err_pulse, 0);
    check("R9 reset sticky", err_sticky, 0);

    // R1 R2 R3 sweep of modes and directions
    for (int mode = 0; mode < 4; mode++) begin
      for (int w = 0; w < 2; w++) begin
        int e;
        e = ((mode == 1 && w == 1) || (mode == 2 && w == 0)) ? 1 : 0;
        acc(2, 5, bit'(w), mode);
        check(mode == 1 ? "R1 create" : (mode == 2 ? "R2 create" : "R3 no create"), resv_active, e);
        if (e == 1) begin
          check("R1 owner", resv_owner, 2);
          check("R2 bank", resv_bank, 5);
          check("R4 block", master_block, blk(2));
          acc(2, 5, bit'(1 - w), mode);
          check("R5 release", resv_active, 0);
          check("R4 block idle", master_block, 0);
        end
      end
    end

    // R5 R6 unaffected accesses, RAW
    acc(1, 3, 1'b1, 1);
    check("R1 owner m1", resv_owner, 1);
    acc(1, 4, 1'b0, 0);
    check("R5 owner other bank", resv_active, 1);
    acc(0, 3, 1'b0, 1);
    check("R5 other master", resv_active, 1);
    acc(0, 6, 1'b1, 1);
    check("R5 no second owner", resv_owner, 1);
    check("R5 no second bank", resv_bank, 3);
    acc(1, 3, 1'b1, 1);
    check("R6 renew keeps", resv_active, 1);
    check("R4 block m1", master_block, blk(1));
    acc(1, 3, 1'b0, 1);
    check("R5 read releases", resv_active, 0);
    check("R8 no pulse on release", err_pulse, 0);

    // WAR renew and release
    acc(0, 0, 1'b0, 2);
    acc(0, 0, 1'b0, 2);
    check("R6 WAR renew keeps", resv_active, 1);
    acc(0, 0, 1'b1, 2);
    check("R5 WAR write releases", resv_active, 0);

    // R7 timeout with reporting disabled
    err_enable = 1'b0;
    acc(3, 7, 1'b1, 1);
    hold_len(n, p);
    check("R7 hold length", n, TO);
    check("R8 no pulse disabled", p, 0);
    check("R8 no sticky disabled", err_sticky, 0);

    // R6 restart then timeout with reporting enabled
    err_enable = 1'b1;
    acc(3, 7, 1'b1, 1);
    idle(100);
    acc(3, 7, 1'b1, 1);
    hold_len(n, p);
    check("R6 window after renew", n, TO);
    check("R8 one pulse", p, 1);
    check("R8 sticky set", err_sticky, 1);
    idle(1);
    check("R8 pulse ends", err_pulse, 0);

    // R7 WAR timeout
    acc(2, 1, 1'b0, 2);
    hold_len(n, p);
    check("R7 WAR hold length", n, TO);

    // R9 sticky clear
    idle(5);
    check("R9 sticky holds", err_sticky, 1);
    err_clear = 1'b1;
    @(posedge clk);
    @(negedge clk);
    err_clear = 1'b0;
    check("R9 sticky cleared", err_sticky, 0);

    finish_up();
  end
endmodule